// File: doc/BRIEF.md
# Shared-Bus Word Memory With CPU Register

This block holds a tiny word-addressed store and a CPU-side register. Both sit on one bidirectional data bus. An address, a read/write line and a memory-select line steer every transfer. The address is decoded into one-hot row selects.

- **Write access.** With memory selected and the line at 0, the CPU register drives the bus. The selected row captures the whole word on the next clock edge.
- **Read access.** With memory selected and the line at 1, an AND-OR network picks the selected row. It drives that row onto the bus through a tri-state enable.
- **Memory not selected.** While memory-select is low the access belongs to an IO device. The store ignores it, and the block leaves the bus undriven so another agent can use it.

The CPU register loads from the bus on its ordinary load input. It also has a forced load from a set of switches, and the forced load wins when both are asserted.

Top module: `shared_bus_mem`

## Requirements
- R1: After reset every row of the store and the CPU register read as zero.
- R2: When `mem_sel`=1 and `rw`=0 at a rising clock edge, the word on `bus` is stored into the row numbered by `addr`.
- R3: A write leaves every row other than the addressed one unchanged.
- R4: While `mem_sel`=1 and `rw`=1, `bus` carries the contents of row `addr` in the same cycle, with no clock edge needed.
- R5: While `mem_sel`=0 no row changes, whatever `rw`, `addr` and `bus` hold, and the block does not drive `bus`.
- R6: While `mem_sel`=1 and `rw`=0, the block drives `bus` with the CPU register value.
- R7: `force_load`=1 at a rising edge loads `sw` into the CPU register, even when `reg_load` is also 1.
- R8: `reg_load`=1 with `force_load`=0 at a rising edge loads the value on `bus` into the CPU register.
- R9: `addr` is a plain binary row number: value n selects row n, for n from 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (2) | Row number |
| rw | input | 1 | 1 = read, 0 = write |
| mem_sel | input | 1 | 1 = memory access, 0 = IO access |
| sw | input | DATA_W (4) | Switch value for forced load |
| force_load | input | 1 | Forced register load, highest priority |
| reg_load | input | 1 | Ordinary register load from bus |
| cpu_reg | output | DATA_W (4) | CPU register contents |
| bus | inout | DATA_W (4) | Shared data bus |

## Verification
The assertions assume that `addr`, `rw` and `mem_sel` change only away from the rising edge. They also assume that no outside agent drives `bus` while `mem_sel` is 1, so the bus value seen at an edge is the block's own drive.

The bench keeps within these assumptions:
- It changes inputs only on falling edges.
- It enables its own IO-device driver only after lowering `mem_sel`.
- It releases that driver before raising `mem_sel` again.

Given that discipline, a value the bench drives during an IO access and reads back intact shows that the block has let go of the bus.

// File: rtl/shared_bus_mem.sv
module shared_bus_mem #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              mem_sel,
  input  logic [DATA_W-1:0] sw,
  input  logic              force_load,
  input  logic              reg_load,
  output logic [DATA_W-1:0] cpu_reg,
  inout  wire  [DATA_W-1:0] bus
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] rows;
  logic [DEPTH-1:0]             sel;
  logic [DATA_W-1:0]            rd_word;
  logic                         wr_stb, rd_en;

  assign wr_stb = mem_sel & ~rw;
  assign rd_en  = mem_sel & rw;

  always_comb begin
    sel = '0;
    sel[addr] = 1'b1;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEPTH; i++)
      rd_word = rd_word | (rows[i] & {DATA_W{sel[i]}});
  end

  assign bus = rd_en  ? rd_word :
               wr_stb ? cpu_reg : {DATA_W{1'bz}};

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                rows[i] <= '0;
      else if (wr_stb && sel[i]) rows[i] <= bus;

    assert_other_rows_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr != ADDR_W'(i)) |=> $stable(rows[i]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cpu_reg <= '0;
    else if (force_load) cpu_reg <= sw;
    else if (reg_load)   cpu_reg <= bus;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> rows[$past(addr)] == $past(bus));

  assert_idle_no_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel |=> $stable(rows));

  assert_read_drives_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> bus == rows[addr]);

  assert_write_drives_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> bus == cpu_reg);

  assert_force_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_load |=> cpu_reg == $past(sw));

  assert_bus_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_load && !force_load) |=> cpu_reg == $past(bus));
endmodule

// File: tb/shared_bus_mem_tb.sv
module shared_bus_mem_tb;
  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       rw = 1, mem_sel = 0, force_load = 0, reg_load = 0;
  logic [3:0] sw = 0, cpu_reg;
  logic       tb_drv = 0;
  logic [3:0] tb_val = 0;
  wire  [3:0] bus;
  int checks = 0, fails = 0;

  assign bus = tb_drv ? tb_val : 4'bzzzz;

  shared_bus_mem u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw),
    .mem_sel(mem_sel), .sw(sw), .force_load(force_load), .reg_load(reg_load),
    .cpu_reg(cpu_reg), .bus(bus));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic force_reg(logic [3:0] v);
    @(negedge clk); sw = v; force_load = 1;
    @(negedge clk); force_load = 0;
  endtask

  task automatic mem_write(logic [1:0] a, logic [3:0] v);
    force_reg(v);
    addr = a; rw = 0; mem_sel = 1;
    #1 chk("R6", bus, v);
    @(negedge clk); mem_sel = 0; rw = 1;
  endtask

  task automatic mem_read(logic [1:0] a, logic [3:0] exp, string req);
    @(negedge clk); addr = a; rw = 1; mem_sel = 1;
    #1 chk(req, bus, exp);
    mem_sel = 0;
  endtask

  task automatic t_reset;
    chk("R1", cpu_reg, 4'h0);
    for (int i = 0; i < 4; i++) mem_read(2'(i), 4'h0, "R1");
  endtask

  task automatic t_write_read;
    mem_write(2'd0, 4'h3); mem_write(2'd1, 4'hA);
    mem_write(2'd2, 4'h5); mem_write(2'd3, 4'hC);
    mem_read(2'd0, 4'h3, "R9"); mem_read(2'd1, 4'hA, "R9");
    mem_read(2'd2, 4'h5, "R2"); mem_read(2'd3, 4'hC, "R2");
  endtask

  task automatic t_isolation;
    mem_write(2'd2, 4'hF);
    mem_read(2'd2, 4'hF, "R2"); mem_read(2'd0, 4'h3, "R3");
    mem_read(2'd1, 4'hA, "R3"); mem_read(2'd3, 4'hC, "R3");
  endtask

  task automatic t_io_ignored;
    @(negedge clk); mem_sel = 0; rw = 0; addr = 2'd1;
    tb_drv = 1; tb_val = 4'h6;
    #1 chk("R5", bus, 4'h6);
    @(negedge clk); rw = 1; tb_val = 4'h9;
    #1 chk("R5", bus, 4'h9);
    @(negedge clk); tb_drv = 0;
    mem_read(2'd1, 4'hA, "R5");
  endtask

  task automatic t_reg_loads;
    @(negedge clk); mem_sel = 0; tb_drv = 1; tb_val = 4'h7; reg_load = 1;
    @(negedge clk); reg_load = 0; tb_drv = 0;
    chk("R8", cpu_reg, 4'h7);
    @(negedge clk); tb_drv = 1; tb_val = 4'h2; sw = 4'hB;
    reg_load = 1; force_load = 1;
    @(negedge clk); reg_load = 0; force_load = 0; tb_drv = 0;
    chk("R7", cpu_reg, 4'hB);
    mem_read(2'd3, 4'hC, "R4");
    @(negedge clk); addr = 2'd3; rw = 1; mem_sel = 1; reg_load = 1;
    @(negedge clk); mem_sel = 0; reg_load = 0;
    chk("R8", cpu_reg, 4'hC);
  endtask

  initial begin
    #3000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write_read;
    t_isolation;
    t_io_ignored;
    t_reg_loads;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule